// File: doc/BRIEF.md
# Double-to-Integer Converter

This block turns a 64-bit double-format floating-point operand into a 64-bit two's-complement integer. The caller picks one of four rounding modes per operation and supplies two trap enables: one for integer overflow and one for inexact results. The result and its flags appear one clock after the operand is presented with `in_valid`.

Out-of-range values do not saturate. When the true integer does not fit, the block returns the low 64 bits of the exact integer, raises the integer-overflow flag, and also raises inexact. Infinities, NaNs and denormal inputs are treated as invalid operations and yield zero.

Top module: `dbl_to_int_cvt`

## Requirements
- R1: A result, its flags and `out_valid` appear on the clock edge after the one that sampled `in_valid` high; `out_valid` is low in the cycle after `in_valid` was low, and all outputs are 0 after reset.
- R2: An operand with exponent field (bits 62:52) all ones, or with exponent field zero and nonzero fraction (bits 51:0), gives result 0 with `invalid` set and no other flag or trap.
- R3: An operand of zero (either sign bit 63) gives result 0 with no flags.
- R4: For a finite operand the integer part is the magnitude with the fraction bits discarded; a magnitude below 1 has integer part 0, with magnitudes in [0.5,1) carrying a half-or-more rounding weight and smaller ones only a below-half one.
- R5: Rounding mode 0 (nearest) adds one when the discarded part is at least one half, and on an exact half clears bit 0 of the result magnitude (ties to even).
- R6: Rounding mode 1 (chop) never changes the integer part.
- R7: Rounding mode 2 adds one to the magnitude of a negative operand with any nonzero discarded part; mode 3 does the same for a positive operand.
- R8: `int_ovf` is set when the rounded magnitude exceeds 2^63-1 for a positive operand or 2^63 for a negative one, or the integer part needs more than 64 bits; the result is then the low 64 bits of the exact signed integer and no rounding is applied.
- R9: `inexact` is set when any discarded part is nonzero or when `int_ovf` is set.
- R10: `ovf_trap` equals `int_ovf` gated by `ovf_trap_en`; `inexact_trap` equals `inexact` gated by `inexact_trap_en`.
- R11: A negative operand yields the two's-complement negation of the rounded magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| op_in | input | 64 | Double-format operand |
| rnd_mode | input | 2 | 0 nearest, 1 chop, 2 toward minus infinity, 3 toward plus infinity |
| ovf_trap_en | input | 1 | Enables the overflow trap output |
| inexact_trap_en | input | 1 | Enables the inexact trap output |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Two's-complement integer result |
| invalid | output | 1 | Invalid-operation flag |
| int_ovf | output | 1 | Integer overflow flag |
| inexact | output | 1 | Inexact flag |
| ovf_trap | output | 1 | Overflow trap request |
| inexact_trap | output | 1 | Inexact trap request |

## Verification
The hardest cases to reach are the boundaries of the integer range: a negative operand of exactly 2^63 that must not overflow while its positive twin must, and an exact one-half at magnitude [0.5,1) where nearest rounding first increments and then clears the bit back to zero. Random operands rarely land on these, so directed encodings hit them, alongside random operands whose exponents are concentrated around the range where the binary point falls inside or just outside the 64-bit integer.

// File: rtl/dbl_to_int_cvt.sv
module dbl_to_int_cvt #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] op_in,
  input  logic [1:0]  rnd_mode,
  input  logic        ovf_trap_en,
  input  logic        inexact_trap_en,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        invalid,
  output logic        int_ovf,
  output logic        inexact,
  output logic        ovf_trap,
  output logic        inexact_trap
);
  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int PAD   = W - FRAC_W - 1;
  localparam int TOP   = W - 1;
  localparam int UBW   = EXP_W + 2;

  localparam logic [1:0] RM_NEAR = 2'd0;
  localparam logic [1:0] RM_CHOP = 2'd1;
  localparam logic [1:0] RM_MINF = 2'd2;
  localparam logic [1:0] RM_PINF = 2'd3;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              ex_ones, is_zero, bad_op;
  logic [W-1:0]      mant;
  logic signed [UBW-1:0] ub;

  assign sgn     = op_in[W-1];
  assign ex      = op_in[W-2 -: EXP_W];
  assign fr      = op_in[FRAC_W-1:0];
  assign ex_ones = &ex;
  assign is_zero = (ex == '0) && (fr == '0);
  assign bad_op  = ex_ones || ((ex == '0) && (fr != '0));
  assign mant    = {1'b1, fr, {PAD{1'b0}}};
  assign ub      = $signed({2'b00, ex}) - UBW'(BIAS);

  logic [W-1:0]   ipart, rbits;
  logic           too_big;
  logic [2*W-1:0] wide;
  logic [6:0]     shl;
  logic signed [UBW-1:0] shx;

  always_comb begin
    ipart   = '0;
    rbits   = '0;
    too_big = 1'b0;
    wide    = '0;
    shl     = '0;
    shx     = '0;
    if (ub < 0) begin
      rbits = (ub == -1) ? mant : W'(1);
    end else if (ub <= TOP) begin
      shl   = 7'(ub) + 7'd1;
      wide  = {{W{1'b0}}, mant} << shl;
      ipart = wide[2*W-1:W];
      rbits = wide[W-1:0];
    end else begin
      too_big = 1'b1;
      shx     = ub - UBW'(TOP);
      ipart   = (shx > UBW'(TOP)) ? '0 : (mant << shx[5:0]);
    end
  end

  logic         any_r, tie, bump;
  logic [W:0]   sum;
  logic [W-1:0] mag;
  logic         over_lim, ovf_c, inx_c;
  logic [W-1:0] res_c;

  assign any_r = |rbits;
  assign tie   = rbits == {1'b1, {(W-1){1'b0}}};

  always_comb begin
    unique case (rnd_mode)
      RM_NEAR: bump = rbits[W-1];
      RM_CHOP: bump = 1'b0;
      RM_MINF: bump = sgn && any_r;
      RM_PINF: bump = !sgn && any_r;
      default: bump = 1'b0;
    endcase
  end

  assign sum = {1'b0, ipart} + {{W{1'b0}}, bump};

  always_comb begin
    mag = sum[W-1:0];
    if (rnd_mode == RM_NEAR && tie) mag[0] = 1'b0;
  end

  assign over_lim = sgn ? (mag > {1'b1, {(W-1){1'b0}}}) : mag[W-1];
  assign ovf_c    = !bad_op && !is_zero && (too_big || sum[W] || over_lim);
  assign inx_c    = !bad_op && !is_zero && (ovf_c || any_r);
  assign res_c    = (bad_op || is_zero) ? '0 : (sgn ? (~mag + W'(1)) : mag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      invalid      <= 1'b0;
      int_ovf      <= 1'b0;
      inexact      <= 1'b0;
      ovf_trap     <= 1'b0;
      inexact_trap <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= res_c;
        invalid      <= bad_op;
        int_ovf      <= ovf_c;
        inexact      <= inx_c;
        ovf_trap     <= ovf_c && ovf_trap_en;
        inexact_trap <= inx_c && inexact_trap_en;
      end
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  invalid_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (result == '0) && !int_ovf && !inexact);
  // R9
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ovf |-> inexact);
  // R10
  ovf_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> int_ovf);
  // R10
  inx_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inexact_trap |-> inexact);
  // R8
  sign_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !int_ovf && !invalid && result[W-1]) |-> $past(op_in[W-1]));
endmodule

// File: tb/dbl_to_int_cvt_tb.sv
module dbl_to_int_cvt_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_in = '0;
  logic [1:0]  rnd_mode = '0;
  logic        ovf_trap_en = 1'b0;
  logic        inexact_trap_en = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid, int_ovf, inexact, ovf_trap, inexact_trap;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl_to_int_cvt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in),
    .rnd_mode(rnd_mode), .ovf_trap_en(ovf_trap_en),
    .inexact_trap_en(inexact_trap_en), .out_valid(out_valid),
    .result(result), .invalid(invalid), .int_ovf(int_ovf),
    .inexact(inexact), .ovf_trap(ovf_trap), .inexact_trap(inexact_trap)
  );

  // returns {invalid, ovf, inexact, result}
  function automatic logic [66:0] ref_conv(input logic [63:0] op, input logic [1:0] m);
    logic s; int e; int ub; int sh;
    logic [51:0] f; logic [63:0] mant, ip, rem, half;
    logic above, tie, any, inc, ovf; logic [64:0] mg; logic [63:0] r;
    s = op[63]; e = int'(op[62:52]); f = op[51:0];
    if (e == 2047 || (e == 0 && f != 0)) return {3'b100, 64'd0};
    if (e == 0) return 67'd0;
    mant = {11'd0, 1'b1, f};
    ub = e - 1023;
    above = 0; tie = 0; any = 0; ip = 0;
    if (ub >= 52) begin
      ip = (ub - 52 >= 64) ? 64'd0 : (mant << (ub - 52));
    end else if (ub >= 0) begin
      sh = 52 - ub;
      ip = mant >> sh;
      rem = mant & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      above = rem > half; tie = rem == half; any = rem != 0;
    end else if (ub == -1) begin
      tie = (f == 0); above = !tie; any = 1;
    end else begin
      any = 1;
    end
    case (m)
      2'd0: inc = above | tie;
      2'd1: inc = 0;
      2'd2: inc = s & any;
      default: inc = !s & any;
    endcase
    mg = {1'b0, ip} + 65'(inc);
    if (m == 2'd0 && tie) mg[0] = 1'b0;
    ovf = mg[64] || (ub > 63) ||
          (s ? (mg[63:0] > 64'h8000_0000_0000_0000) : (mg[63:0] > 64'h7FFF_FFFF_FFFF_FFFF));
    r = s ? (~mg[63:0] + 64'd1) : mg[63:0];
    return {1'b0, ovf, ovf | any, r};
  endfunction

  function automatic string tag_of(input logic [63:0] op, input logic [1:0] m, input logic [66:0] ex);
    if (ex[66]) return "R2";
    if (op[62:0] == 63'd0) return "R3";
    if (ex[65]) return "R8";
    case (m)
      2'd0: return "R5";
      2'd1: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run(input logic [63:0] op, input logic [1:0] m,
                     input logic oe, input logic ie, input string tag);
    logic [66:0] ex;
    logic [68:0] exp_v, act_v;
    ex = ref_conv(op, m);
    @(negedge clk);
    op_in = op; rnd_mode = m; ovf_trap_en = oe; inexact_trap_en = ie; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_v = {1'b1, ex[63:0], ex[66], ex[65], ex[64], ex[65] & oe, ex[64] & ie};
    exp_v = {exp_v[68:0]};
    act_v = {out_valid, result, invalid, int_ovf, inexact, ovf_trap, inexact_trap};
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s op=%h mode=%0d actual=%h expected=%h", tag, op, m, act_v, exp_v);
    end
  endtask

  task automatic run_auto(input logic [63:0] op, input logic [1:0] m, input logic oe, input logic ie);
    run(op, m, oe, ie, tag_of(op, m, ref_conv(op, m)));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    total++;
    if ({out_valid, result, invalid, int_ovf, inexact, ovf_trap, inexact_trap} !== '0) begin
      bad++;
      $display("FAIL R1 reset actual=%h expected=0", result);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle valid actual=%b expected=0", out_valid);
    end

    run(64'h7FF0_0000_0000_0000, 2'd0, 1, 1, "R2");
    run(64'h7FF8_0000_0000_0001, 2'd3, 1, 1, "R2");
    run(64'h0000_0000_0000_0001, 2'd2, 1, 1, "R2");
    run(64'h8000_0000_0000_0000, 2'd2, 1, 1, "R3");
    run(64'h0000_0000_0000_0000, 2'd3, 1, 1, "R3");
    run(64'h3FE0_0000_0000_0000, 2'd0, 0, 1, "R5");
    run(64'h3FF8_0000_0000_0000, 2'd0, 0, 1, "R5");
    run(64'h4004_0000_0000_0000, 2'd0, 0, 1, "R5");
    run(64'h4004_0000_0000_0000, 2'd1, 0, 0, "R6");
    run(64'h4004_0000_0000_0000, 2'd1, 0, 1, "R9");
    run(64'hC004_0000_0000_0000, 2'd2, 0, 0, "R7");
    run(64'hC004_0000_0000_0000, 2'd3, 0, 0, "R7");
    run(64'h3FD3_3333_3333_3333, 2'd3, 0, 0, "R7");
    run(64'h3FD3_3333_3333_3333, 2'd1, 0, 0, "R4");
    run(64'hC008_0000_0000_0000, 2'd0, 1, 1, "R11");
    run(64'h43E0_0000_0000_0000, 2'd0, 1, 1, "R8");
    run(64'hC3E0_0000_0000_0000, 2'd0, 1, 1, "R8");
    run(64'h43F0_0000_0000_0000, 2'd1, 1, 0, "R8");
    run(64'h43F0_0000_0000_0001, 2'd1, 0, 1, "R10");
    run(64'h7E37_E43C_8800_759C, 2'd3, 1, 1, "R8");
    run(64'h43DF_FFFF_FFFF_FFFF, 2'd0, 1, 1, "R4");

    for (int i = 0; i < 800; i++) begin
      logic [63:0] op;
      logic [10:0] e;
      int pick;
      pick = $urandom % 20;
      if (pick == 0) e = 11'h7FF;
      else if (pick == 1) e = 11'h000;
      else e = 11'(953 + ($urandom % 150));
      op = {1'($urandom), e, 20'($urandom), 32'($urandom)};
      if (pick == 2) op[51:0] = '0;
      run_auto(op, 2'($urandom), 1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 valid drop actual=%b expected=0", out_valid);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule